// File: doc/BRIEF.md
# Interprocessor and Interval Timer Interrupt Unit

This unit holds one 64-bit control and status word that several processors share. It also holds a separate interval ignore counter for each of four processors. Software uses the shared word to raise and clear interprocessor interrupts, to acknowledge interval timer interrupts, to claim two 4-bit arbitration fields and to keep a small plain read/write field. A single periodic timer tick is counted by every processor's counter. When a counter goes past zero, its sticky overflow bit sets that processor's timer interrupt.

All accesses go through one synchronous 64-bit register port. Each access carries the id of the processor that issues it. Read data is combinational and is valid in the same cycle as the read request. Writes take effect at the next rising clock edge. The interrupt outputs are taken straight from the stored status bits, so each one changes on the edge that updates its bit.

Top module: `ipi_timer_unit`

## Requirements
- R1: After reset, the status word (address 0x080) reads 0x0000_0008_0000_0000 (bit 35 is a fixed revision code), every counter reads 0, and all interrupt outputs are low.
- R2: A read of the status word returns the requesting processor id in bits 1:0. The stored word keeps those two bits at zero.
- R3: Writing 1 to request bit 12+i sets status bit 8+i. The request bits are never stored and read back as 0. Output `ipi_o[i]` equals status bit 8+i.
- R4: Writing 1 to any bit in mask 0x1000_0FF0 clears that bit. This covers timer bits 7:4 and interprocessor bits 11:8. `timer_irq_o[i]` equals status bit 4+i, so it drops when that bit is cleared.
- R5: Writing 1 to bit 20 clears both arbitration fields (bits 23:20 and 19:16) before any set in the same write is applied.
- R6: Bits 23:20 are write-one-to-set. Ones already present stay set.
- R7: Bits 19:16 take the written ones only when the field is all zero after the step in R5. Otherwise the field is left unchanged.
- R8: Every write to the status word replaces bits 43:40 with the written value. No write can change any other bit, including the revision bit.
- R9: The four counters sit at 0x380, 0x3C0, 0x700 and 0x740 (processors 0 to 3). A write stores the low 24 bits and clears bit 24. A read returns the 25-bit value, zero-extended.
- R10: On each rising edge of `tick_i`, every counter not written in that cycle decrements as a 25-bit value that wraps. Bit 24 stays set once it is set. Without a write or a tick, the outputs hold.
- R11: When a tick leaves bit 24 of counter i set, status bit 4+i and `timer_irq_o[i]` are set. The set is applied after any clear in the same cycle. A counter write in the same cycle wins over the tick.
- R12: A falling `tick_i`, or a `tick_i` held high for several cycles, causes no decrement beyond the single rising edge.
- R13: Reads of any other address return 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_cpu | input | 2 | Id of the processor making the access |
| reg_rdata | output | 64 | Read data, valid in the same cycle as a read |
| tick_i | input | 1 | Shared periodic timer level, counted on its rising edge |
| ipi_o | output | 4 | Interprocessor interrupt for each processor |
| timer_irq_o | output | 4 | Interval timer interrupt for each processor |

## Verification
A write, or a rising tick presented before a clock edge, shows its effect on `ipi_o`, `timer_irq_o` and every later read right after that edge. There is no extra stage for the tick: its edge detector compares the live input with its registered copy. Read data depends only on the current request and the stored state, so it is due in the cycle the read is presented. The bench drives inputs on the falling edge and samples a quarter period later, which is after the last update and before the next rising edge. Its model updates on each rising edge and is compared with the outputs at that same sample point in every cycle. Extra hand-computed reads check the arbitration sequences and the counter wrap.

// File: rtl/ipi_timer_pkg.sv
package ipi_timer_pkg;
  localparam int NUM_CPU     = 4;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 64;
  localparam int CPU_W       = $clog2(NUM_CPU);

  // status word field positions (decoded by software, so fixed)
  localparam int ITI_LSB     = 4;
  localparam int IPI_LSB     = 8;
  localparam int IPREQ_LSB   = 12;
  localparam int ARB_LO_LSB  = 16;
  localparam int ARB_HI_LSB  = 20;
  localparam int ARB_W       = 4;
  localparam int ARB_CLR_BIT = 20;
  localparam int RW_LSB      = 40;
  localparam int RW_W        = 4;

  localparam logic [DATA_W-1:0] W1C_MASK  = 64'h0000_0000_1000_0FF0;
  localparam logic [DATA_W-1:0] RESET_VAL = 64'h0000_0008_0000_0000;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h080;

  function automatic logic [ADDR_W-1:0] cnt_addr(input int idx);
    if (idx < 2) cnt_addr = ADDR_W'(12'h380 + idx * 12'h040);
    else         cnt_addr = ADDR_W'(12'h700 + (idx - 2) * 12'h040);
  endfunction
endpackage

// File: rtl/ipit_tick_edge.sv
module ipit_tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic rise_o
);
  logic tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_i;
  end

  assign rise_o = tick_i & ~tick_q;
endmodule

// File: rtl/ipit_interval_cnt.sv
module ipit_interval_cnt #(
  parameter int CNT_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic           tick_rise,
  output logic [CNT_W:0] cnt_o,
  output logic           ovf_o
);
  localparam int FULL_W = CNT_W + 1;

  logic [FULL_W-1:0] cnt_q, cnt_d, dec;
  logic              cnt_en;

  always_comb begin
    dec    = cnt_q - FULL_W'(1);
    cnt_d  = cnt_q;
    cnt_en = wr_en | tick_rise;
    if (wr_en)          cnt_d = {1'b0, wdata};
    else if (tick_rise) cnt_d = {cnt_q[CNT_W] | dec[CNT_W], dec[CNT_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = tick_rise & ~wr_en & cnt_d[CNT_W];
endmodule

// File: rtl/ipit_status_reg.sv
module ipit_status_reg
  import ipi_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CPU-1:0] iti_set,
  output logic [DATA_W-1:0] stat_o
);
  logic [DATA_W-1:0] stat_q, stat_d;
  logic              stat_en;

  always_comb begin
    stat_d  = stat_q;
    stat_en = wr_en | (|iti_set);
    if (wr_en) begin
      stat_d = stat_d & ~(wdata & W1C_MASK);
      if (wdata[ARB_CLR_BIT]) begin
        stat_d[ARB_HI_LSB +: ARB_W] = '0;
        stat_d[ARB_LO_LSB +: ARB_W] = '0;
      end
      stat_d[ARB_HI_LSB +: ARB_W] = stat_d[ARB_HI_LSB +: ARB_W] | wdata[ARB_HI_LSB +: ARB_W];
      if (stat_d[ARB_LO_LSB +: ARB_W] == '0)
        stat_d[ARB_LO_LSB +: ARB_W] = wdata[ARB_LO_LSB +: ARB_W];
      stat_d[IPI_LSB +: NUM_CPU] = stat_d[IPI_LSB +: NUM_CPU] | wdata[IPREQ_LSB +: NUM_CPU];
      stat_d[RW_LSB +: RW_W]     = wdata[RW_LSB +: RW_W];
    end
    stat_d[ITI_LSB +: NUM_CPU] = stat_d[ITI_LSB +: NUM_CPU] | iti_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= RESET_VAL;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ipi_timer_unit.sv
module ipi_timer_unit
  import ipi_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic [1:0]        reg_cpu,
  output logic [63:0]       reg_rdata,
  input  logic              tick_i,
  output logic [3:0]        ipi_o,
  output logic [3:0]        timer_irq_o
);
  localparam int NCPU = NUM_CPU;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              wr, rd, stat_hit, tick_rise;
  logic [NCPU-1:0]   cnt_hit, iti_set;
  logic [CNT_W:0]    cnt_val [NCPU];
  logic [DATA_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign wr       = reg_en & reg_we;
  assign rd       = reg_en & ~reg_we;
  assign stat_hit = (reg_addr == STATUS_ADDR);

  ipit_tick_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_i (tick_i),
    .rise_o (tick_rise)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cnt
    assign cnt_hit[g] = (reg_addr == cnt_addr(g));
    ipit_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_en     (wr & cnt_hit[g]),
      .wdata     (reg_wdata[CNT_W-1:0]),
      .tick_rise (tick_rise),
      .cnt_o     (cnt_val[g]),
      .ovf_o     (iti_set[g])
    );
  end

  ipit_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr & stat_hit),
    .wdata   (reg_wdata),
    .iti_set (iti_set),
    .stat_o  (stat_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      if (stat_hit) reg_rdata = stat_q | {{(DATA_W-CPU_W){1'b0}}, reg_cpu};
      for (int i = 0; i < NCPU; i++)
        if (cnt_hit[i]) reg_rdata = DATA_W'(cnt_val[i]);
    end
  end

  assign ipi_o       = stat_q[IPI_LSB +: NCPU];
  assign timer_irq_o = stat_q[ITI_LSB +: NCPU];
endmodule

// File: rtl/ipi_timer_chk.sv
module ipi_timer_chk
  import ipi_timer_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_en,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic [63:0] reg_wdata,
  input logic [1:0]  reg_cpu,
  input logic [63:0] reg_rdata,
  input logic        tick_i,
  input logic [3:0]  ipi_o,
  input logic [3:0]  timer_irq_o
);
  logic stat_wr, stat_rd;
  assign stat_wr = reg_en & reg_we & (reg_addr == STATUS_ADDR);
  assign stat_rd = reg_en & ~reg_we & (reg_addr == STATUS_ADDR);

  AST_REQ_SETS_IPI: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((ipi_o & $past(reg_wdata[15:12])) == $past(reg_wdata[15:12]))); // R3

  AST_ITI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !tick_i) |=> ((timer_irq_o & $past(reg_wdata[7:4])) == 4'b0000)); // R4

  AST_ITI_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(timer_irq_o & ~$past(timer_irq_o))) |-> $past(tick_i)); // R11

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_en && reg_we) && !tick_i) |=> ($stable(ipi_o) && $stable(timer_irq_o))); // R10

  AST_REVISION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> reg_rdata[35]); // R8

  AST_CPU_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (reg_rdata[1:0] == reg_cpu)); // R2
endmodule

bind ipi_timer_unit ipi_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_cpu     (reg_cpu),
  .reg_rdata   (reg_rdata),
  .tick_i      (tick_i),
  .ipi_o       (ipi_o),
  .timer_irq_o (timer_irq_o)
);

// File: tb/ipi_timer_unit_test.sv
`timescale 1ns/1ps
module ipi_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0, tick_i = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [1:0]  reg_cpu = '0;
  logic [63:0] reg_rdata;
  logic [3:0]  ipi_o, timer_irq_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  ipi_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
    .reg_rdata(reg_rdata), .tick_i(tick_i), .ipi_o(ipi_o),
    .timer_irq_o(timer_irq_o)
  );

  // behavioural reference model
  logic [63:0] m_word;
  longint      m_cnt [4];
  bit          m_prev;

  function automatic int cnt_index(input logic [11:0] a);
    case (a)
      12'h380: return 0;
      12'h3C0: return 1;
      12'h700: return 2;
      12'h740: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 64'h0000_0008_0000_0000;
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_prev = 0;
    end else begin
      bit rising;
      int widx;
      rising = tick_i && !m_prev;
      m_prev = tick_i;
      widx = -1;
      if (reg_en && reg_we) begin
        if (reg_addr == 12'h080) begin
          for (int b = 0; b < 64; b++)
            if (reg_wdata[b] && (b == 28 || (b >= 4 && b <= 11))) m_word[b] = 1'b0;
          if (reg_wdata[20]) m_word[23:16] = 8'h00;
          m_word[23:20] = m_word[23:20] | reg_wdata[23:20];
          if (m_word[19:16] == 4'h0) m_word[19:16] = reg_wdata[19:16];
          m_word[11:8] = m_word[11:8] | reg_wdata[15:12];
          m_word[43:40] = reg_wdata[43:40];
        end
        widx = cnt_index(reg_addr);
        if (widx >= 0) m_cnt[widx] = longint'(reg_wdata[23:0]);
      end
      if (rising)
        for (int k = 0; k < 4; k++)
          if (k != widx) begin
            longint keep;
            keep = m_cnt[k] & 64'h100_0000;
            m_cnt[k] = ((m_cnt[k] - 1) & 64'h1FF_FFFF) | keep;
            if (m_cnt[k] >= 64'h100_0000) m_word[4+k] = 1'b1;
          end
    end
  end

  function automatic logic [63:0] model_read();
    int idx;
    if (!reg_en || reg_we) return 64'h0;
    if (reg_addr == 12'h080) return m_word | {62'h0, reg_cpu};
    idx = cnt_index(reg_addr);
    if (idx >= 0) return 64'(m_cnt[idx]);
    return 64'h0;
  endfunction

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      n_checks++;
      if (ipi_o !== m_word[11:8]) begin
        n_fail++;
        $display("FAIL R3 per-cycle ipi_o act=%b exp=%b", ipi_o, m_word[11:8]);
      end
      n_checks++;
      if (timer_irq_o !== m_word[7:4]) begin
        n_fail++;
        $display("FAIL R11 per-cycle timer_irq_o act=%b exp=%b", timer_irq_o, m_word[7:4]);
      end
      n_checks++;
      if (reg_rdata !== model_read()) begin
        n_fail++;
        $display("FAIL R13 per-cycle reg_rdata act=%h exp=%h", reg_rdata, model_read());
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] cpu,
                    input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a; reg_cpu = cpu;
    #5 chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_en = 0; reg_cpu = 0;
  endtask

  task automatic outs(input logic [3:0] e_ipi, input logic [3:0] e_tmr, input string tag);
    @(negedge clk);
    #5;
    chk({tag, " ipi_o"}, 64'(ipi_o), 64'(e_ipi));
    chk({tag, " timer_irq_o"}, 64'(timer_irq_o), 64'(e_tmr));
  endtask

  task automatic tick(input int hold);
    @(negedge clk);
    tick_i = 1;
    repeat (hold) @(negedge clk);
    tick_i = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h080, 2'd0, 64'h0000_0008_0000_0000, "R1 status reset");
    rd(12'h380, 2'd0, 64'h0, "R1 counter reset");
    outs(4'h0, 4'h0, "R1 outputs reset");
    // R2 processor id
    rd(12'h080, 2'd3, 64'h0000_0008_0000_0003, "R2 cpu id 3");

    // R3 request bits set ipi
    wr(12'h080, 64'h5000);
    outs(4'b0101, 4'h0, "R3 request");
    rd(12'h080, 2'd0, 64'h0000_0008_0000_0500, "R3 request not stored");
    // R4 clear ipi bit 8
    wr(12'h080, 64'h0100);
    outs(4'b0100, 4'h0, "R4 ipi clear");
    // R5/R6/R7 arbitration fields
    wr(12'h080, 64'h0035_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_0035_0400, "R5 R6 clear then set");
    wr(12'h080, 64'h0002_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_0035_0400, "R7 low field busy");
    wr(12'h080, 64'h00C0_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_00F5_0400, "R6 high field accumulate");
    wr(12'h080, 64'h0010_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_0010_0400, "R5 clear both");
    // R8 rw field, revision fixed
    wr(12'h080, 64'hFFFF_FA00_0000_0000);
    rd(12'h080, 2'd2, 64'h0000_0A08_0010_0402, "R8 rw field");

    // R9 counters
    wr(12'h380, 64'h64);
    wr(12'h3C0, 64'hFF00_0002);
    wr(12'h700, 64'h300);
    wr(12'h740, 64'h10);
    rd(12'h3C0, 2'd0, 64'h2, "R9 low 24 bits");
    rd(12'h700, 2'd0, 64'h300, "R9 counter cpu2");

    // R12 held tick counts once
    tick(3);
    rd(12'h3C0, 2'd0, 64'h1, "R12 held tick");
    rd(12'h380, 2'd0, 64'h63, "R10 decrement");
    tick(1);
    rd(12'h3C0, 2'd0, 64'h0, "R10 reach zero");
    outs(4'b0100, 4'h0, "R11 no irq at zero");
    tick(1);
    rd(12'h3C0, 2'd0, 64'h1FF_FFFF, "R10 wrap");
    outs(4'b0100, 4'b0010, "R11 overflow irq");
    rd(12'h080, 2'd0, 64'h0000_0A08_0010_0420, "R11 status bit");
    wr(12'h080, 64'h20);
    outs(4'b0100, 4'b0000, "R4 timer clear");
    tick(1);
    rd(12'h3C0, 2'd0, 64'h1FF_FFFE, "R10 sticky");
    outs(4'b0100, 4'b0010, "R11 irq again");
    rd(12'h380, 2'd0, 64'h60, "R10 cpu0 after four ticks");

    wr(12'h080, 64'h20);
    wr(12'h3C0, 64'h5);
    rd(12'h3C0, 2'd0, 64'h5, "R9 write clears overflow");
    tick(1);
    rd(12'h3C0, 2'd0, 64'h4, "R9 decrement after rewrite");
    outs(4'b0100, 4'b0000, "R9 no irq after rewrite");

    // R11 write wins over tick in the same cycle
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = 12'h740; reg_wdata = 64'h7; tick_i = 1;
    @(negedge clk);
    reg_en = 0; reg_we = 0; tick_i = 0;
    rd(12'h740, 2'd0, 64'h7, "R11 write beats tick");

    // R13 unmapped
    wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h100, 2'd0, 64'h0, "R13 unmapped read");
    rd(12'h080, 2'd0, 64'h0000_0008_0010_0400, "R13 unmapped write ignored");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule